// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This unit turns an instruction's addressing information into the memory address that a load/store unit uses for its operand. Each request carries a mode code, a base register value, an index register value, an operand size, a 32-bit immediate field and the current program counter. For most modes the address appears one clock after the request, together with a one-cycle valid strobe.

Two modes that update a pointer also produce the new register value and a write enable in the same cycle as the address. Post-increment uses the register and then steps it. Pre-decrement steps the register first and then uses it. In memory-indirect mode the unit first reads a pointer from memory. It holds a read request and a busy flag until the read data arrives. On the next clock it presents the returned pointer as the operand address. New requests are ignored while the unit is busy.

Top module: `ea_unit`

## Requirements
- R1: After reset, `ea_valid`, `wb_en`, `busy` and `ptr_rd_req` are all low.
- R2: Absolute mode (code 0): one clock after an accepted `start`, `ea` equals the full 32-bit `imm` field and `ea_valid` is high.
- R3: Register indirect (code 1) gives `ea` = `base_reg`, and `imm` is ignored. Register plus displacement (code 2) gives `ea` = `base_reg` + `imm[15:0]` sign-extended.
- R4: Post-increment (code 3): `ea` = `base_reg`. `wb_data` = `base_reg` + step and `wb_en` is high, in the same cycle as `ea_valid`.
- R5: Pre-decrement (code 4): `ea` and `wb_data` both equal `base_reg` − step, and `wb_en` is high with `ea_valid`.
- R6: The `size` code sets the step: 00 is 1 byte, 01 is 2 bytes, 10 is 4 bytes. The reserved code 11 behaves as 10.
- R7: Indexed (code 5): `ea` = `base_reg` + (`index_reg` shifted left by the size code, with 11 shifting by 2).
- R8: PC-relative (code 6): `ea` = `pc` + 4 + `imm[15:0]` sign-extended. The 4 is the length of one instruction in bytes.
- R9: Memory indirect (code 7) has two steps.
  - One clock after `start`, `busy` and `ptr_rd_req` are high with `ptr_rd_addr` = `imm`.
  - They stay high until a clock that samples `ptr_rd_valid`.
  - One clock later, `ea` equals the sampled `ptr_rd_data`, `ea_valid` is high and `busy` is low.
- R10: A `start` while `busy` is high is ignored. No `ea_valid` follows it, and `ptr_rd_addr` does not change.
- R11: `ea_valid` lasts one cycle per request. `wb_en` is high only for codes 3 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, accepted when not busy |
| mode | input | 3 | Addressing mode code (0..7) |
| base_reg | input | 32 | Base/pointer register value |
| index_reg | input | 32 | Index register value |
| size | input | 2 | Operand size code |
| imm | input | 32 | Absolute address, displacement (low 16 bits) or pointer location |
| pc | input | 32 | Address of the current instruction |
| ea | output | 32 | Effective address |
| ea_valid | output | 1 | One-cycle strobe qualifying `ea` |
| wb_data | output | 32 | Updated pointer value |
| wb_en | output | 1 | Pointer write-back enable |
| ptr_rd_req | output | 1 | Pointer read request (memory indirect) |
| ptr_rd_addr | output | 32 | Address of the pointer to read |
| ptr_rd_data | input | 32 | Returned pointer value |
| ptr_rd_valid | input | 1 | Pointer read data valid |
| busy | output | 1 | Indirect fetch in progress |

## Verification
The embedded assertions run on every cycle. They check the following:
- pointer write-back occurs only alongside a valid address;
- post-increment and pre-decrement relate `wb_data` and `ea` to the base register and the step;
- a request is never outstanding while idle;
- an indirect fetch holds its pointer address steady until data returns;
- the returned pointer becomes the address one clock later.

Some behaviour only the directed scenarios can show:
- the exact arithmetic of each mode, including negative displacements and the wrap of PC-relative offsets;
- the mapping of each size code, including the reserved one;
- that a request during an indirect fetch leaves no trace;
- the reset state.

// File: rtl/ea_unit.sv
module ea_unit #(
  parameter int AW = 32,
  parameter int DISP_W = 16,
  parameter int INSTR_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    mode,
  input  logic [AW-1:0] base_reg,
  input  logic [AW-1:0] index_reg,
  input  logic [1:0]    size,
  input  logic [AW-1:0] imm,
  input  logic [AW-1:0] pc,
  output logic [AW-1:0] ea,
  output logic          ea_valid,
  output logic [AW-1:0] wb_data,
  output logic          wb_en,
  output logic          ptr_rd_req,
  output logic [AW-1:0] ptr_rd_addr,
  input  logic [AW-1:0] ptr_rd_data,
  input  logic          ptr_rd_valid,
  output logic          busy
);
  localparam logic [2:0] M_ABS  = 3'd0;
  localparam logic [2:0] M_RIND = 3'd1;
  localparam logic [2:0] M_RDSP = 3'd2;
  localparam logic [2:0] M_PINC = 3'd3;
  localparam logic [2:0] M_PDEC = 3'd4;
  localparam logic [2:0] M_IDX  = 3'd5;
  localparam logic [2:0] M_PCR  = 3'd6;
  localparam logic [2:0] M_MIND = 3'd7;
  localparam logic [AW-1:0] NEXT_OFS = AW'(INSTR_BYTES);

  logic          waiting;
  logic [1:0]    shamt;
  logic [AW-1:0] step, disp_x, scaled, calc_ea, calc_wb;
  logic          accept;

  assign shamt  = (size == 2'b11) ? 2'd2 : size;
  assign step   = AW'(1) << shamt;
  assign scaled = index_reg << shamt;
  assign disp_x = {{(AW-DISP_W){imm[DISP_W-1]}}, imm[DISP_W-1:0]};
  assign accept = start && !waiting;

  always_comb begin
    calc_wb = base_reg;
    case (mode)
      M_ABS:   calc_ea = imm;
      M_RIND:  calc_ea = base_reg;
      M_RDSP:  calc_ea = base_reg + disp_x;
      M_PINC: begin
        calc_ea = base_reg;
        calc_wb = base_reg + step;
      end
      M_PDEC: begin
        calc_ea = base_reg - step;
        calc_wb = base_reg - step;
      end
      M_IDX:   calc_ea = base_reg + scaled;
      M_PCR:   calc_ea = pc + NEXT_OFS + disp_x;
      default: calc_ea = imm;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      waiting     <= 1'b0;
      ea          <= '0;
      ea_valid    <= 1'b0;
      wb_data     <= '0;
      wb_en       <= 1'b0;
      ptr_rd_addr <= '0;
    end else begin
      ea_valid <= 1'b0;
      wb_en    <= 1'b0;
      if (accept) begin
        if (mode == M_MIND) begin
          waiting     <= 1'b1;
          ptr_rd_addr <= imm;
        end else begin
          ea       <= calc_ea;
          ea_valid <= 1'b1;
          wb_data  <= calc_wb;
          wb_en    <= (mode == M_PINC) || (mode == M_PDEC);
        end
      end else if (waiting && ptr_rd_valid) begin
        waiting  <= 1'b0;
        ea       <= ptr_rd_data;
        ea_valid <= 1'b1;
      end
    end
  end

  assign busy       = waiting;
  assign ptr_rd_req = waiting;

  a_r1_req_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_rd_req |-> busy);
  a_r11_wb_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> ea_valid);
  a_r4_post_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mode == M_PINC) |=> (ea_valid && wb_en && ea == $past(base_reg)
      && wb_data == $past(base_reg) + $past(step)));
  a_r5_pre_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mode == M_PDEC) |=> (ea_valid && wb_en && ea == wb_data
      && ea == $past(base_reg) - $past(step)));
  a_r9_ptr_to_ea: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ptr_rd_valid) |=> (ea_valid && !busy && ea == $past(ptr_rd_data)));
  a_r10_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ptr_rd_valid) |=> (busy && !ea_valid && $stable(ptr_rd_addr)));
  a_r9_enter_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mode == M_MIND) |=> (busy && !ea_valid && ptr_rd_addr == $past(imm)));
endmodule

// File: tb/ea_unit_bench.sv
`timescale 1ns/1ps
module ea_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  mode = '0;
  logic [31:0] base_reg = '0, index_reg = '0, imm = '0, pc = '0;
  logic [1:0]  size = '0;
  logic [31:0] ptr_rd_data = '0;
  logic        ptr_rd_valid = 1'b0;
  logic [31:0] ea, wb_data, ptr_rd_addr;
  logic        ea_valid, wb_en, ptr_rd_req, busy;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ea_unit u_ea_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .base_reg(base_reg),
    .index_reg(index_reg), .size(size), .imm(imm), .pc(pc), .ea(ea),
    .ea_valid(ea_valid), .wb_data(wb_data), .wb_en(wb_en), .ptr_rd_req(ptr_rd_req),
    .ptr_rd_addr(ptr_rd_addr), .ptr_rd_data(ptr_rd_data), .ptr_rd_valid(ptr_rd_valid),
    .busy(busy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] m, input logic [1:0] s, input logic [31:0] b,
                       input logic [31:0] x, input logic [31:0] im, input logic [31:0] p);
    @(negedge clk);
    mode = m; size = s; base_reg = b; index_reg = x; imm = im; pc = p; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic expect_ea(input string tag, input logic [31:0] exp_ea,
                           input logic exp_wben, input logic [31:0] exp_wb);
    chk({tag, " ea_valid"}, 32'(ea_valid), 32'd1);
    chk({tag, " ea"}, ea, exp_ea);
    chk({tag, " wb_en R11"}, 32'(wb_en), 32'(exp_wben));
    if (exp_wben) chk({tag, " wb_data"}, wb_data, exp_wb);
    @(negedge clk);
    chk({tag, " ea_valid pulse R11"}, 32'(ea_valid), 32'd0);
  endtask

  task automatic t_reset;
    chk("R1 ea_valid", 32'(ea_valid), 32'd0);
    chk("R1 wb_en", 32'(wb_en), 32'd0);
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 ptr_rd_req", 32'(ptr_rd_req), 32'd0);
  endtask

  task automatic t_absolute;
    issue(3'd0, 2'b10, 32'hAAAA_0000, 32'h0, 32'h1234_5678, 32'h0);
    expect_ea("R2 abs", 32'h1234_5678, 1'b0, 32'h0);
  endtask

  task automatic t_reg_modes;
    issue(3'd1, 2'b10, 32'h0000_1000, 32'h0, 32'h0000_FFFF, 32'h0);
    expect_ea("R3 reg indirect", 32'h0000_1000, 1'b0, 32'h0);
    issue(3'd2, 2'b10, 32'h0000_2000, 32'h0, 32'h7777_FFF8, 32'h0);
    expect_ea("R3 disp negative", 32'h0000_1FF8, 1'b0, 32'h0);
    issue(3'd2, 2'b00, 32'h0000_2000, 32'h0, 32'h0000_0010, 32'h0);
    expect_ea("R3 disp positive", 32'h0000_2010, 1'b0, 32'h0);
  endtask

  task automatic t_post_inc;
    issue(3'd3, 2'b10, 32'h0000_3000, 32'h0, 32'h0, 32'h0);
    expect_ea("R4 postinc word", 32'h0000_3000, 1'b1, 32'h0000_3004);
    issue(3'd3, 2'b00, 32'h0000_3000, 32'h0, 32'h0, 32'h0);
    expect_ea("R4 R6 postinc byte", 32'h0000_3000, 1'b1, 32'h0000_3001);
    issue(3'd3, 2'b01, 32'hFFFF_FFFF, 32'h0, 32'h0, 32'h0);
    expect_ea("R4 R6 postinc half wrap", 32'hFFFF_FFFF, 1'b1, 32'h0000_0001);
  endtask

  task automatic t_pre_dec;
    issue(3'd4, 2'b01, 32'h0000_4000, 32'h0, 32'h0, 32'h0);
    expect_ea("R5 predec half", 32'h0000_3FFE, 1'b1, 32'h0000_3FFE);
    issue(3'd4, 2'b11, 32'h0000_4000, 32'h0, 32'h0, 32'h0);
    expect_ea("R5 R6 predec reserved size", 32'h0000_3FFC, 1'b1, 32'h0000_3FFC);
  endtask

  task automatic t_indexed;
    issue(3'd5, 2'b00, 32'h0000_5000, 32'd3, 32'h0, 32'h0);
    expect_ea("R7 idx byte", 32'h0000_5003, 1'b0, 32'h0);
    issue(3'd5, 2'b01, 32'h0000_5000, 32'd3, 32'h0, 32'h0);
    expect_ea("R7 idx half", 32'h0000_5006, 1'b0, 32'h0);
    issue(3'd5, 2'b10, 32'h0000_5000, 32'd3, 32'h0, 32'h0);
    expect_ea("R7 idx word", 32'h0000_500C, 1'b0, 32'h0);
    issue(3'd5, 2'b11, 32'h0000_5000, 32'd3, 32'h0, 32'h0);
    expect_ea("R7 R6 idx reserved", 32'h0000_500C, 1'b0, 32'h0);
  endtask

  task automatic t_pc_rel;
    issue(3'd6, 2'b10, 32'h0, 32'h0, 32'h0000_FFF0, 32'h0000_0100);
    expect_ea("R8 pcrel back", 32'h0000_00F4, 1'b0, 32'h0);
    issue(3'd6, 2'b10, 32'h0, 32'h0, 32'h0000_0020, 32'h0000_0100);
    expect_ea("R8 pcrel fwd", 32'h0000_0124, 1'b0, 32'h0);
  endtask

  task automatic t_mem_indirect;
    issue(3'd7, 2'b10, 32'h0, 32'h0, 32'h0000_8000, 32'h0);
    chk("R9 busy", 32'(busy), 32'd1);
    chk("R9 req", 32'(ptr_rd_req), 32'd1);
    chk("R9 ptr addr", ptr_rd_addr, 32'h0000_8000);
    chk("R9 no early valid", 32'(ea_valid), 32'd0);
    mode = 3'd0; imm = 32'h0000_9999; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10 ignored no valid", 32'(ea_valid), 32'd0);
    chk("R10 ptr addr held", ptr_rd_addr, 32'h0000_8000);
    chk("R10 still busy", 32'(busy), 32'd1);
    @(negedge clk);
    chk("R9 req held", 32'(ptr_rd_req), 32'd1);
    ptr_rd_data = 32'hDEAD_BEE0; ptr_rd_valid = 1'b1;
    @(negedge clk);
    ptr_rd_valid = 1'b0; ptr_rd_data = 32'h0;
    chk("R9 not busy", 32'(busy), 32'd0);
    chk("R9 req dropped", 32'(ptr_rd_req), 32'd0);
    expect_ea("R9 final", 32'hDEAD_BEE0, 1'b0, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_absolute();
    t_reg_modes();
    t_post_inc();
    t_pre_dec();
    t_indexed();
    t_pc_rel();
    t_mem_indirect();
    t_absolute();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule